// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block lets a clocked host read and write an external asynchronous static RAM of 128K words by 8 bits. The host raises a request with an address, a read/write flag and write data, holds it, and sees a one-clock acknowledge when the access is complete; read data is presented with that acknowledge. On the memory side the controller drives a 17-bit address, an active-low and an active-high chip select, an active-low output enable and an active-low write enable, and a split data bus (output value, output enable, input value) that the chip top turns into a bidirectional pad.

Every setup, pulse-width, access and turnaround limit of the memory is given in picoseconds as a parameter. The controller converts each to a whole number of clock cycles (rounded up, at least one) and holds each bus phase for that many cycles. A write is framed by the overlap of chip select and write enable, with a setup phase before the write-enable pulse and a hold phase after it. The controller drives data only during the pulse and the hold phase, and after a read it waits for the memory to release the bus before it drives again. Between requests the memory is left deselected, in standby.

Top module: `sram_ctrl`

## Requirements
- R1: During and after reset, with no request, write enable (`mem_we_n`) and output enable (`mem_oe_n`) are 1, `mem_dq_oe` is 0, `req_ack` is 0 and the memory is deselected (`mem_sel_n`=1, `mem_sel`=0).
- R2: A write holds `mem_we_n` low for at least ceil(max(10 ns write pulse, 7 ns data setup)/clock) consecutive cycles, only while the memory is selected, and the byte on `mem_dq_out` during that pulse is stored at `mem_addr`.
- R3: `mem_dq_oe` is 1 only while the write-enable pulse or the one hold cycle after it is in progress, and never while `mem_oe_n` is 0.
- R4: A read holds the memory selected with `mem_we_n`=1 and `mem_oe_n`=0 for ceil(max(12 ns access, 12 ns cycle)/clock) cycles, captures `mem_dq_in` on the last of them, and presents that byte on `rsp_rdata` while `req_ack` is 1 and until the next read.
- R5: Each accepted request produces `req_ack`=1 for exactly one clock cycle.
- R6: After a read, `mem_dq_oe` does not rise until `mem_oe_n` has been 1 for at least ceil(6 ns/clock) cycles; a write that directly follows a read inserts that many turnaround cycles before its setup phase.
- R7: Whenever no request is in progress the memory is deselected (`mem_sel_n`=1, `mem_sel`=0) and `mem_dq_oe` is 0.
- R8: Counting clock edges from the one that accepts the request to the one that raises `req_ack`: a write takes 1+S+P edges, plus T when the previous access was a read; a read takes 1+A edges. S, P, A and T are each ceil(limit/clock period), at least 1 (S from the 0 ns address setup, P as in R2 and also so that the write spans at least 12 ns, A as in R4, T as in R6).
- R9: `mem_addr` does not change while the memory stays selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present; held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last read data |
| mem_addr | output | 17 | Memory address |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tri-state enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data received from the memory pins |

## Verification
The two functions that can meet in one cycle are the end of a read, when the output enable rises and the memory may still drive the bus, and the start of a following write, when the controller wants the bus. The bench provokes this by issuing a write as soon as a read is acknowledged, both directed and within a random mix of reads and writes to a small address set, while a memory model in the bench tracks how long the memory keeps driving after output enable rises. It judges the case by flagging any cycle in which both sides drive, by the write's acknowledge latency including the turnaround cycles, and by reading the written byte back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_WSETUP,
    PH_WPULSE,
    PH_WHOLD,
    PH_RACC,
    PH_RACK
  } phase_t;

  // Whole cycles needed to cover a time limit, never fewer than one.
  function automatic int wait_cycles(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold the value n.
  function automatic int bits_for(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_ctrl_pkg::*;
(
  input  phase_t phase,
  output logic   sel_on,
  output logic   oe_on,
  output logic   we_on,
  output logic   drive_on,
  output logic   ack_on
);

  always_comb begin
    sel_on   = 1'b0;
    oe_on    = 1'b0;
    we_on    = 1'b0;
    drive_on = 1'b0;
    ack_on   = 1'b0;
    case (phase)
      PH_WSETUP: sel_on = 1'b1;
      PH_WPULSE: begin sel_on = 1'b1; we_on = 1'b1; drive_on = 1'b1; end
      PH_WHOLD:  begin sel_on = 1'b1; drive_on = 1'b1; ack_on = 1'b1; end
      PH_RACC:   begin sel_on = 1'b1; oe_on = 1'b1; end
      PH_RACK:   ack_on = 1'b1;
      default:   ;
    endcase
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW          = 17,
  parameter int DW          = 8,
  parameter int CLK_PS      = 5000,
  parameter int T_ASETUP_PS = 0,
  parameter int T_WPULSE_PS = 10000,
  parameter int T_DSETUP_PS = 7000,
  parameter int T_ACCESS_PS = 12000,
  parameter int T_CYCLE_PS  = 12000,
  parameter int T_OEHIZ_PS  = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int SETUP_CYC = wait_cycles(T_ASETUP_PS, CLK_PS);
  localparam int PULSE_CYC = max_of(max_of(wait_cycles(T_WPULSE_PS, CLK_PS),
                                           wait_cycles(T_DSETUP_PS, CLK_PS)),
                                    wait_cycles(T_CYCLE_PS, CLK_PS) - SETUP_CYC - 1);
  localparam int READ_CYC  = max_of(wait_cycles(T_ACCESS_PS, CLK_PS),
                                    wait_cycles(T_CYCLE_PS, CLK_PS));
  localparam int TURN_CYC  = wait_cycles(T_OEHIZ_PS, CLK_PS);
  localparam int MAX_CYC   = max_of(max_of(SETUP_CYC, PULSE_CYC), max_of(READ_CYC, TURN_CYC));
  localparam int CW        = bits_for(MAX_CYC);

  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] READ_LD  = CW'(READ_CYC - 1);
  localparam logic [CW-1:0] TURN_LD  = CW'(TURN_CYC - 1);

  phase_t        phase, phase_nxt;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;
  logic          accept, capture;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rd_last;
  logic          sel_on, oe_on, we_on, drive_on, ack_on;

  sram_wait_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_pin_decode u_decode (
    .phase    (phase),
    .sel_on   (sel_on),
    .oe_on    (oe_on),
    .we_on    (we_on),
    .drive_on (drive_on),
    .ack_on   (ack_on)
  );

  always_comb begin
    phase_nxt = phase;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    accept    = 1'b0;
    capture   = 1'b0;
    case (phase)
      PH_IDLE: if (req_valid) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        if (!req_write) begin
          phase_nxt = PH_RACC;
          tmr_val   = READ_LD;
        end else if (rd_last) begin
          phase_nxt = PH_TURN;
          tmr_val   = TURN_LD;
        end else begin
          phase_nxt = PH_WSETUP;
          tmr_val   = SETUP_LD;
        end
      end
      PH_TURN: if (tmr_expired) begin
        phase_nxt = PH_WSETUP;
        tmr_load  = 1'b1;
        tmr_val   = SETUP_LD;
      end
      PH_WSETUP: if (tmr_expired) begin
        phase_nxt = PH_WPULSE;
        tmr_load  = 1'b1;
        tmr_val   = PULSE_LD;
      end
      PH_WPULSE: if (tmr_expired) phase_nxt = PH_WHOLD;
      PH_WHOLD:  phase_nxt = PH_IDLE;
      PH_RACC: if (tmr_expired) begin
        capture   = 1'b1;
        phase_nxt = PH_RACK;
      end
      PH_RACK:   phase_nxt = PH_IDLE;
      default:   phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rd_last <= 1'b0;
    end else begin
      phase <= phase_nxt;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        if (req_write) rd_last <= 1'b0;
      end
      if (capture)          rdata_q <= mem_dq_in;
      if (phase == PH_RACK) rd_last <= 1'b1;
    end
  end

  assign req_ack    = ack_on;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_sel_n  = ~sel_on;
  assign mem_sel    = sel_on;
  assign mem_oe_n   = ~oe_on;
  assign mem_we_n   = ~we_on;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = drive_on;

  // Observation counters for the timing assertions (saturating run lengths).
  logic [CW:0] we_low_run, oe_low_run, oe_high_run;
  logic        selected;
  assign selected = ~mem_sel_n & mem_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_run  <= '0;
      oe_low_run  <= '0;
      oe_high_run <= '1;
    end else begin
      we_low_run  <= mem_we_n ? '0 : ((&we_low_run) ? we_low_run : we_low_run + 1'b1);
      oe_low_run  <= mem_oe_n ? '0 : ((&oe_low_run) ? oe_low_run : oe_low_run + 1'b1);
      oe_high_run <= !mem_oe_n ? '0 : ((&oe_high_run) ? oe_high_run : oe_high_run + 1'b1);
    end
  end

  AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> we_low_run >= (CW+1)'(PULSE_CYC)); // R2
  AST_WE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> selected); // R2
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R3
  AST_READ_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> oe_low_run >= (CW+1)'(READ_CYC)); // R4
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack); // R5
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> oe_high_run >= (CW+1)'(TURN_CYC)); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    selected && $past(selected) |-> $stable(mem_addr)); // R9

endmodule

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;

  localparam int CLK = 5000;  // ps, 200 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ack;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  always #2500ps clk = ~clk;

  sram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Smallest whole cycle count n with n*CLK >= t (at least one).
  function automatic int need(input int t_ps);
    int n = 1;
    while (n * CLK < t_ps) n++;
    return n;
  endfunction

  function automatic int imax(input int a, input int b);
    if (a >= b) return a;
    return b;
  endfunction

  function automatic logic [7:0] fill(input logic [16:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  int s_cyc, p_cyc, a_cyc, t_cyc;
  initial begin
    s_cyc = need(0);
    p_cyc = imax(imax(need(10000), need(7000)), need(12000) - s_cyc - 1);
    a_cyc = imax(need(12000), need(12000));
    t_cyc = need(6000);
  end

  function automatic int lat_exp(input bit wr, input bit after_rd);
    if (!wr) return 1 + a_cyc;
    return 1 + s_cyc + p_cyc + (after_rd ? t_cyc : 0);
  endfunction

  // ---------------- memory model ----------------
  logic [7:0] mem [int];
  logic [7:0] exp_mem [int];
  int  rd_age = 0, oe_hi_age = 100, we_pulse = 0;
  logic [16:0] pend_a, prev_addr;
  logic [7:0]  pend_d;
  bit   prev_sel = 0, prev_dq_oe = 0;
  logic sel, drv;
  logic [7:0] stored;

  assign sel    = !mem_sel_n && mem_sel;
  assign drv    = sel && mem_we_n && !mem_oe_n;
  assign stored = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : fill(mem_addr);
  assign mem_dq_in = drv ? ((rd_age >= a_cyc - 1) ? stored : ~stored)
                         : (mem_dq_oe ? mem_dq_out : 8'h00);

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && drv) chk(0, "R3 contention with memory read", 1, 0);
      if (mem_dq_oe && !prev_dq_oe)
        chk(oe_hi_age >= t_cyc, "R6 bus driven before memory release", oe_hi_age, t_cyc);
      if (sel && prev_sel && mem_addr != prev_addr)
        chk(0, "R9 address moved while selected", mem_addr, prev_addr);
      if (!mem_we_n) begin
        if (!sel) chk(0, "R2 write enable while deselected", 0, 1);
        if (mem_dq_oe) we_pulse = we_pulse + 1;
        pend_a = mem_addr;
        pend_d = mem_dq_out;
      end else if (we_pulse != 0 || !prev_we) begin
        chk(we_pulse >= p_cyc, "R2 write pulse cycles with data valid", we_pulse, p_cyc);
        mem[int'(pend_a)] = pend_d;
        we_pulse = 0;
      end
    end
    rd_age     <= drv ? rd_age + 1 : 0;
    oe_hi_age  <= mem_oe_n ? ((oe_hi_age < 100) ? oe_hi_age + 1 : 100) : 0;
    prev_sel   = sel;
    prev_addr  = mem_addr;
    prev_dq_oe = mem_dq_oe;
    prev_we    = mem_we_n;
  end
  bit prev_we = 1;

  // ---------------- stimulus ----------------
  bit last_rd = 0;

  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int n;
    logic [7:0] e;
    chk(mem_sel_n && !mem_sel && !mem_dq_oe, "R7 standby between requests",
        {mem_sel_n, mem_sel, mem_dq_oe}, 3'b100);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ack && n < 40);
    chk(n == lat_exp(wr, last_rd), wr ? "R8 write latency" : "R8 read latency", n, lat_exp(wr, last_rd));
    if (!wr) begin
      e = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : fill(a);
      chk(rsp_rdata == e, "R4 read data", rsp_rdata, e);
    end else begin
      exp_mem[int'(a)] = d;
    end
    req_valid = 0;
    @(negedge clk);
    chk(!req_ack, "R5 acknowledge single cycle", req_ack, 0);
    last_rd = !wr;
  endtask

  initial begin
    logic [16:0] pool [8];
    int unsigned r;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(mem_we_n && mem_oe_n && !mem_dq_oe && mem_sel_n && !mem_sel && !req_ack,
        "R1 reset state", {mem_we_n, mem_oe_n, mem_dq_oe, mem_sel_n, mem_sel, req_ack}, 6'b110100);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk(mem_we_n && mem_oe_n && !mem_dq_oe && mem_sel_n && !req_ack,
        "R1 idle after reset", {mem_we_n, mem_oe_n, mem_dq_oe, mem_sel_n, req_ack}, 5'b11010);

    // directed corners
    do_op(0, 17'h00000, 8'h00);          // R4 unwritten location
    do_op(1, 17'h00000, 8'hA5);          // R6 write right after read
    do_op(0, 17'h00000, 8'h00);
    do_op(1, 17'h1FFFF, 8'h5A);          // R2 top address
    do_op(1, 17'h1FFFF, 8'hC3);          // overwrite, write after write
    do_op(0, 17'h1FFFF, 8'h00);
    do_op(1, 17'h10001, 8'hFF);          // R6 again, read then write

    for (int i = 0; i < 8; i++) pool[i] = 17'($urandom());
    for (int i = 0; i < 60; i++) begin
      bit wr = $urandom() % 2;
      logic [16:0] a = pool[$urandom() % 8];
      logic [7:0]  d = 8'($urandom());
      int gap = $urandom() % 3;
      repeat (gap) @(negedge clk);
      do_op(wr, a, d);
    end
    for (int i = 0; i < 8; i++) do_op(0, pool[i], 8'h00);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule